// File: doc/BRIEF.md
# Raster Timing Generator with Window Fill

This block produces the sync, data-enable and pixel stream for one video output. Software programs it through a word-addressed register port. Horizontal positions are pixel columns within a line. Vertical positions are not line numbers: they are absolute pixel-clock offsets measured from the start of the frame, so a frame-level start or end may fall at any pixel.

Inside the programmed display window the block passes upstream pixels through, using a valid/ready handshake. Two optional inner limits can narrow the window in which upstream pixels are taken: one for columns and one for frame offsets. Display-window pixels outside those limits are filled with a border colour. When upstream has no pixel ready in the active area, a separate underflow colour is shown instead. A programmable one-cycle fetch pulse marks a chosen frame offset. Frame and line counters can be read back.

The sequencer has three states, named here together with every transition:
- `ST_IDLE`: generation is off. It moves to `ST_START` when the enable register holds 1.
- `ST_START`: a one-cycle state that clears the counters and loads the working timing set. It moves to `ST_RUN` if enable is still 1, and back to `ST_IDLE` otherwise.
- `ST_RUN`: one pixel is produced per clock. It returns to `ST_IDLE` as soon as enable reads 0.

Top module: `dte_timing_engine`

## Requirements
- R1: The register at word address 3 holds the line length in pixel clocks in bits 31:16 and the hsync width in bits 15:0. Before polarity is applied, hsync is high while the column counter is below the width. The column counter runs from 0 up to the line length minus 1 and then wraps.
- R2: Before polarity is applied, vsync is high while the frame pixel counter is below the value at word 7. The frame pixel counter runs from 0 up to the value at word 6 minus 1 and then wraps.
- R3: Word 4 holds the last display column in bits 31:16 and the first display column in bits 15:0. Word 8 holds the first display frame offset and word 9 the last. Data-enable is high only when both the column and the frame offset lie inside these inclusive ranges. In the active part of that window, the input pixel is passed to the output and ready is high.
- R4: In the active part of the display window, when the input valid is low, the output pixel is the colour at word 14.
- R5: When config (word 1) bit 29 is set, display pixels whose column lies outside the inclusive range at word 5 (end in 31:16, start in 15:0) show the colour at word 13, with ready low.
- R6: When config bit 30 is set, display pixels whose frame offset lies outside the inclusive range from word 10 to word 11 show the border colour, with ready low.
- R7: In word 2, bit 0 inverts hsync, bit 1 inverts vsync and bit 2 inverts data-enable.
- R8: When config bit 31 is set, a fetch output pulses high for the single cycle in which the frame pixel counter equals word 12. When bit 31 is clear, the fetch output stays low.
- R9: Writing 1 to bit 0 of word 0 starts generation, and the frame pixel counter reads 0 two clock edges after the write edge. Writing 0 stops generation. While stopped, outputs sit at their inactive levels, the pixel output is 0 and ready is low.
- R10: Word 16 reads the line index within the current frame, and word 15 reads the number of frames completed since the start. Both read 0 while generation is stopped. A read returns its data on the clock edge after the request, with the values sampled at that request.
- R11: Writes to words 1 to 14 take effect only at the next frame boundary or at start. The frame in progress keeps its timing.
- R12: After reset all registers are 0 and every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Register write word address |
| reg_wr_data | input | 32 | Register write data |
| reg_rd_en | input | 1 | Register read strobe |
| reg_rd_addr | input | ADDR_W | Register read word address |
| reg_rd_data | output | 32 | Read data, one cycle after the request |
| pix_in_valid | input | 1 | Upstream pixel valid |
| pix_in_data | input | PIX_W | Upstream pixel |
| pix_in_ready | output | 1 | Pixel accepted this cycle |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| de_o | output | 1 | Data enable after polarity |
| pix_out | output | PIX_W | Output pixel |
| fetch_start_o | output | 1 | Programmable fetch pulse |

## Verification
The assertions assume that software programs a frame length that is a whole multiple of the line length, and that it gives a non-zero line length and frame length before it sets enable. Without this, the wrap and stepping properties would compare against degenerate limits. The stimulus writes a complete, consistent timing set while the engine is idle. After that it only changes window, config and polarity words in the middle of a frame, never the period words. Reads and writes go to mapped addresses only, so the readback path never sees an undecoded address during a checked read.

// File: rtl/dte_pkg.sv
package dte_pkg;
    localparam int REG_W = 32;

    localparam int A_ENABLE = 0;
    localparam int A_CFG    = 1;
    localparam int A_POL    = 2;
    localparam int A_HCTL   = 3;
    localparam int A_DHCTL  = 4;
    localparam int A_AHCTL  = 5;
    localparam int A_VPER   = 6;
    localparam int A_VPULSE = 7;
    localparam int A_DVS    = 8;
    localparam int A_DVE    = 9;
    localparam int A_AVS    = 10;
    localparam int A_AVE    = 11;
    localparam int A_FETCH  = 12;
    localparam int A_BORDER = 13;
    localparam int A_UNDER  = 14;
    localparam int A_FRAMES = 15;
    localparam int A_LINES  = 16;

    localparam int CFG_ACT_H = 29;
    localparam int CFG_ACT_V = 30;
    localparam int CFG_FETCH = 31;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_START = 2'd1,
        ST_RUN   = 2'd2
    } dte_state_e;

    typedef struct packed {
        logic [REG_W-1:0] cfg;
        logic [REG_W-1:0] pol;
        logic [REG_W-1:0] hctl;
        logic [REG_W-1:0] dhctl;
        logic [REG_W-1:0] ahctl;
        logic [REG_W-1:0] vper;
        logic [REG_W-1:0] vpulse;
        logic [REG_W-1:0] dvs;
        logic [REG_W-1:0] dve;
        logic [REG_W-1:0] avs;
        logic [REG_W-1:0] ave;
        logic [REG_W-1:0] fetch;
        logic [REG_W-1:0] border;
        logic [REG_W-1:0] under;
    } dte_timing_t;
endpackage

// File: rtl/dte_regs.sv
module dte_regs
    import dte_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int FCNT_W = 16,
    parameter int LCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [REG_W-1:0]  rd_data,
    input  logic              load_i,
    input  logic              eng_on_i,
    input  logic [FCNT_W-1:0] frame_cnt_i,
    input  logic [LCNT_W-1:0] line_cnt_i,
    output logic              enable_o,
    output dte_timing_t       act_o
);
    dte_timing_t pend_q;
    dte_timing_t act_q;
    logic        en_q;
    logic [REG_W-1:0] rd_mux;
    logic        counts_live;

    // Pending (software-visible) set
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (int'(wr_addr))
                A_ENABLE: en_q          <= wr_data[0];
                A_CFG:    pend_q.cfg    <= wr_data;
                A_POL:    pend_q.pol    <= wr_data;
                A_HCTL:   pend_q.hctl   <= wr_data;
                A_DHCTL:  pend_q.dhctl  <= wr_data;
                A_AHCTL:  pend_q.ahctl  <= wr_data;
                A_VPER:   pend_q.vper   <= wr_data;
                A_VPULSE: pend_q.vpulse <= wr_data;
                A_DVS:    pend_q.dvs    <= wr_data;
                A_DVE:    pend_q.dve    <= wr_data;
                A_AVS:    pend_q.avs    <= wr_data;
                A_AVE:    pend_q.ave    <= wr_data;
                A_FETCH:  pend_q.fetch  <= wr_data;
                A_BORDER: pend_q.border <= wr_data;
                A_UNDER:  pend_q.under  <= wr_data;
                default: ;
            endcase
        end
    end

    // Working set, copied only at a frame boundary or at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q <= '0;
        end else if (load_i) begin
            act_q <= pend_q;
        end
    end

    assign counts_live = eng_on_i && en_q;

    always_comb begin
        rd_mux = '0;
        unique case (int'(rd_addr))
            A_ENABLE: rd_mux = {{(REG_W-1){1'b0}}, en_q};
            A_CFG:    rd_mux = pend_q.cfg;
            A_POL:    rd_mux = pend_q.pol;
            A_HCTL:   rd_mux = pend_q.hctl;
            A_DHCTL:  rd_mux = pend_q.dhctl;
            A_AHCTL:  rd_mux = pend_q.ahctl;
            A_VPER:   rd_mux = pend_q.vper;
            A_VPULSE: rd_mux = pend_q.vpulse;
            A_DVS:    rd_mux = pend_q.dvs;
            A_DVE:    rd_mux = pend_q.dve;
            A_AVS:    rd_mux = pend_q.avs;
            A_AVE:    rd_mux = pend_q.ave;
            A_FETCH:  rd_mux = pend_q.fetch;
            A_BORDER: rd_mux = pend_q.border;
            A_UNDER:  rd_mux = pend_q.under;
            A_FRAMES: rd_mux = counts_live ? REG_W'(frame_cnt_i) : '0;
            A_LINES:  rd_mux = counts_live ? REG_W'(line_cnt_i) : '0;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= rd_mux;
        end
    end

    assign enable_o = en_q;
    assign act_o    = act_q;

    // R11: the working set only moves when the sequencer asks for a load
    p_hold_between_loads_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(act_q));

    // R10: counts read back as zero once generation is off
    p_counts_zero_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !eng_on_i && (int'(rd_addr) == A_FRAMES)) |=> (rd_data == '0));
endmodule

// File: rtl/dte_seq.sv
module dte_seq
    import dte_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int HCNT_W = 16,
    parameter int FCNT_W = 16,
    parameter int LCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [CNT_W-1:0]  vper_i,
    input  logic [HCNT_W-1:0] hper_i,
    output logic              running_o,
    output logic              eng_on_o,
    output logic              load_o,
    output logic [CNT_W-1:0]  pix_cnt_o,
    output logic [HCNT_W-1:0] h_cnt_o,
    output logic [LCNT_W-1:0] line_cnt_o,
    output logic [FCNT_W-1:0] frame_cnt_o
);
    dte_state_e state_q, state_d;
    logic [CNT_W-1:0]  pix_q;
    logic [HCNT_W-1:0] h_q;
    logic [LCNT_W-1:0] line_q;
    logic [FCNT_W-1:0] frame_q;
    logic frame_wrap, h_wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = enable_i ? ST_START : ST_IDLE;
            ST_START: state_d = enable_i ? ST_RUN   : ST_IDLE;
            ST_RUN:   state_d = enable_i ? ST_RUN   : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign frame_wrap = (state_q == ST_RUN) &&
                        ((vper_i == '0) || (pix_q >= vper_i - 1'b1));
    assign h_wrap     = (state_q == ST_RUN) &&
                        ((hper_i == '0) || (h_q >= hper_i - 1'b1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q   <= '0;
            h_q     <= '0;
            line_q  <= '0;
            frame_q <= '0;
        end else if (state_q == ST_START) begin
            pix_q   <= '0;
            h_q     <= '0;
            line_q  <= '0;
            frame_q <= '0;
        end else if (state_q == ST_RUN) begin
            pix_q <= frame_wrap ? '0 : pix_q + 1'b1;
            h_q   <= (frame_wrap || h_wrap) ? '0 : h_q + 1'b1;
            if (frame_wrap)  line_q <= '0;
            else if (h_wrap) line_q <= line_q + 1'b1;
            if (frame_wrap)  frame_q <= frame_q + 1'b1;
        end
    end

    assign running_o   = (state_q == ST_RUN);
    assign eng_on_o    = (state_q != ST_IDLE);
    assign load_o      = (state_q == ST_START) || frame_wrap;
    assign pix_cnt_o   = pix_q;
    assign h_cnt_o     = h_q;
    assign line_cnt_o  = line_q;
    assign frame_cnt_o = frame_q;

    p_start_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START) |=> (pix_q == '0) && (frame_q == '0) && (line_q == '0));

    p_frame_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        frame_wrap |=> (frame_q == $past(frame_q) + 1'b1) && (pix_q == '0));

    p_pix_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_RUN) && !frame_wrap) |=> (pix_q == $past(pix_q) + 1'b1));

    p_stop_goes_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dte_pixel.sv
module dte_pixel
    import dte_pkg::*;
#(
    parameter int PIX_W  = 24,
    parameter int CNT_W  = 32,
    parameter int HCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              running_i,
    input  logic [CNT_W-1:0]  pix_cnt_i,
    input  logic [HCNT_W-1:0] h_cnt_i,
    input  dte_timing_t       tm_i,
    input  logic              in_valid_i,
    input  logic [PIX_W-1:0]  in_data_i,
    output logic              in_ready_o,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic              fetch_o,
    output logic [PIX_W-1:0]  pix_o
);
    logic hs_raw, vs_raw, in_disp, act_h_ok, act_v_ok, in_act;
    logic [HCNT_W-1:0] dh_first, dh_last, ah_first, ah_last;

    assign dh_first = tm_i.dhctl[HCNT_W-1:0];
    assign dh_last  = tm_i.dhctl[REG_W-1:REG_W-HCNT_W];
    assign ah_first = tm_i.ahctl[HCNT_W-1:0];
    assign ah_last  = tm_i.ahctl[REG_W-1:REG_W-HCNT_W];

    always_comb begin
        hs_raw   = running_i && (h_cnt_i < tm_i.hctl[HCNT_W-1:0]);
        vs_raw   = running_i && (pix_cnt_i < tm_i.vpulse[CNT_W-1:0]);
        in_disp  = running_i &&
                   (h_cnt_i >= dh_first) && (h_cnt_i <= dh_last) &&
                   (pix_cnt_i >= tm_i.dvs[CNT_W-1:0]) &&
                   (pix_cnt_i <= tm_i.dve[CNT_W-1:0]);
        act_h_ok = !tm_i.cfg[CFG_ACT_H] ||
                   ((h_cnt_i >= ah_first) && (h_cnt_i <= ah_last));
        act_v_ok = !tm_i.cfg[CFG_ACT_V] ||
                   ((pix_cnt_i >= tm_i.avs[CNT_W-1:0]) &&
                    (pix_cnt_i <= tm_i.ave[CNT_W-1:0]));
        in_act   = in_disp && act_h_ok && act_v_ok;

        if (!in_disp)        pix_o = '0;
        else if (!in_act)    pix_o = tm_i.border[PIX_W-1:0];
        else if (in_valid_i) pix_o = in_data_i;
        else                 pix_o = tm_i.under[PIX_W-1:0];
    end

    assign in_ready_o = in_act;
    assign hsync_o    = hs_raw  ^ tm_i.pol[0];
    assign vsync_o    = vs_raw  ^ tm_i.pol[1];
    assign de_o       = in_disp ^ tm_i.pol[2];
    assign fetch_o    = running_i && tm_i.cfg[CFG_FETCH] &&
                        (pix_cnt_i == tm_i.fetch[CNT_W-1:0]);

    p_ready_inside_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready_o |-> (de_o != tm_i.pol[2]));

    p_fetch_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_o |-> (tm_i.cfg[CFG_FETCH] && running_i));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !running_i |-> (!fetch_o && !in_ready_o && (pix_o == '0) &&
                        (hsync_o == tm_i.pol[0])));

    p_underflow_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !in_valid_i) |-> (pix_o == tm_i.under[PIX_W-1:0]));
endmodule

// File: rtl/dte_timing_engine.sv
module dte_timing_engine
    import dte_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int PIX_W  = 24,
    parameter int CNT_W  = 32,
    parameter int FCNT_W = 16,
    parameter int LCNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [31:0]       reg_wr_data,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [31:0]       reg_rd_data,
    input  logic              pix_in_valid,
    input  logic [PIX_W-1:0]  pix_in_data,
    output logic              pix_in_ready,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              de_o,
    output logic [PIX_W-1:0]  pix_out,
    output logic              fetch_start_o
);
    localparam int HCNT_W = REG_W / 2;

    dte_timing_t       tm;
    logic              enable, running, eng_on, load;
    logic [CNT_W-1:0]  pix_cnt;
    logic [HCNT_W-1:0] h_cnt;
    logic [LCNT_W-1:0] line_cnt;
    logic [FCNT_W-1:0] frame_cnt;

    dte_regs #(.ADDR_W(ADDR_W), .FCNT_W(FCNT_W), .LCNT_W(LCNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
        .rd_en(reg_rd_en), .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
        .load_i(load), .eng_on_i(eng_on),
        .frame_cnt_i(frame_cnt), .line_cnt_i(line_cnt),
        .enable_o(enable), .act_o(tm)
    );

    dte_seq #(.CNT_W(CNT_W), .HCNT_W(HCNT_W), .FCNT_W(FCNT_W), .LCNT_W(LCNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable_i(enable),
        .vper_i(tm.vper[CNT_W-1:0]), .hper_i(tm.hctl[REG_W-1:REG_W-HCNT_W]),
        .running_o(running), .eng_on_o(eng_on), .load_o(load),
        .pix_cnt_o(pix_cnt), .h_cnt_o(h_cnt),
        .line_cnt_o(line_cnt), .frame_cnt_o(frame_cnt)
    );

    dte_pixel #(.PIX_W(PIX_W), .CNT_W(CNT_W), .HCNT_W(HCNT_W)) u_pixel (
        .clk(clk), .rst_n(rst_n), .running_i(running),
        .pix_cnt_i(pix_cnt), .h_cnt_i(h_cnt), .tm_i(tm),
        .in_valid_i(pix_in_valid), .in_data_i(pix_in_data),
        .in_ready_o(pix_in_ready),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .fetch_o(fetch_start_o), .pix_o(pix_out)
    );
endmodule

// File: tb/dte_timing_engine_bench.sv
module dte_timing_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 5;
    localparam int PIX_W  = 24;
    localparam logic [PIX_W-1:0] IN_PIX = 24'hABCDEF;
    localparam logic [PIX_W-1:0] BORDER = 24'h00FF00;
    localparam logic [PIX_W-1:0] UNDER  = 24'hFF0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic in_valid = 1'b1;
    logic [PIX_W-1:0] in_data = IN_PIX;
    logic in_ready, hs, vs, de, fetch;
    logic [PIX_W-1:0] pix;

    int n_checks = 0, n_fail = 0, cur = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dte_timing_engine u_dte_timing_engine (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(wr_en), .reg_wr_addr(wr_addr), .reg_wr_data(wr_data),
        .reg_rd_en(rd_en), .reg_rd_addr(rd_addr), .reg_rd_data(rd_data),
        .pix_in_valid(in_valid), .pix_in_data(in_data), .pix_in_ready(in_ready),
        .hsync_o(hs), .vsync_o(vs), .de_o(de), .pix_out(pix), .fetch_start_o(fetch)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cur++;
    endtask

    task automatic goto_pix(input int n);
        while (cur < n) tick();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at pix %0d: actual %0h expected %0h", req, cur, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = ADDR_W'(a); wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
        rd_en = 1'b1; rd_addr = ADDR_W'(a);
        tick();
        rd_en = 1'b0;
        chk(req, rd_data, exp);
    endtask

    task automatic t_reset();   // R12
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R12 hsync", 32'(hs), 0);
        chk("R12 de", 32'(de), 0);
        chk("R12 pix", 32'(pix), 0);
        chk("R12 ready", 32'(in_ready), 0);
        rd_chk("R12 frames", 15, 0);
    endtask

    task automatic t_start();   // R9
        wr(3, (32'd10 << 16) | 32'd2);
        wr(6, 32'd60);
        wr(7, 32'd10);
        wr(8, 32'd20);
        wr(9, 32'd49);
        wr(4, (32'd7 << 16) | 32'd4);
        wr(13, 32'(BORDER));
        wr(14, 32'(UNDER));
        wr(12, 32'd15);
        wr(2, 32'd0);
        wr(1, 32'd0);
        wr(0, 32'd1);
        tick();
        tick();
        cur = 0;
        chk("R9 first pixel hsync", 32'(hs), 1);
    endtask

    task automatic t_sync();    // R1 R2 R8
        chk("R2 vsync at 0", 32'(vs), 1);
        chk("R3 de at 0", 32'(de), 0);
        goto_pix(2);  chk("R1 hsync end", 32'(hs), 0);
        goto_pix(10); chk("R2 vsync end", 32'(vs), 0);
                      chk("R1 hsync next line", 32'(hs), 1);
        goto_pix(15); chk("R8 fetch disabled", 32'(fetch), 0);
    endtask

    task automatic t_display(); // R3 R4 R11
        goto_pix(23); chk("R3 de before", 32'(de), 0);
        goto_pix(24); chk("R3 de first", 32'(de), 1);
                      chk("R3 pass", 32'(pix), 32'(IN_PIX));
                      chk("R3 ready", 32'(in_ready), 1);
        goto_pix(25); in_valid = 1'b0;
                      #1 chk("R4 underflow", 32'(pix), 32'(UNDER));
                      chk("R4 de", 32'(de), 1);
        in_valid = 1'b1;
        wr(5, (32'd6 << 16) | 32'd5);
        wr(1, 32'hA000_0000);
        goto_pix(34); chk("R11 old frame pass", 32'(pix), 32'(IN_PIX));
                      chk("R11 old frame ready", 32'(in_ready), 1);
        goto_pix(47); chk("R3 de last col", 32'(de), 1);
        goto_pix(48); chk("R3 de past col", 32'(de), 0);
        goto_pix(54); chk("R3 de past vend", 32'(de), 0);
    endtask

    task automatic t_active_h(); // R5 R8 R10
        goto_pix(74); chk("R8 fetch before", 32'(fetch), 0);
        goto_pix(75); chk("R8 fetch pulse", 32'(fetch), 1);
        goto_pix(76); chk("R8 fetch after", 32'(fetch), 0);
        goto_pix(84); chk("R5 border", 32'(pix), 32'(BORDER));
                      chk("R5 ready low", 32'(in_ready), 0);
                      chk("R5 de", 32'(de), 1);
        goto_pix(85); chk("R5 inside", 32'(pix), 32'(IN_PIX));
        goto_pix(87); chk("R5 border right", 32'(pix), 32'(BORDER));
        goto_pix(90);
        rd_chk("R10 line index", 16, 3);
        rd_chk("R10 frame count", 15, 1);
        wr(10, 32'd30);
        wr(11, 32'd39);
        wr(1, 32'h4000_0000);
    endtask

    task automatic t_active_v(); // R6 R8
        goto_pix(135); chk("R8 fetch off", 32'(fetch), 0);
        goto_pix(144); chk("R6 border top", 32'(pix), 32'(BORDER));
        goto_pix(154); chk("R6 inside", 32'(pix), 32'(IN_PIX));
                       chk("R6 ready", 32'(in_ready), 1);
        goto_pix(164); chk("R6 border bottom", 32'(pix), 32'(BORDER));
        goto_pix(170); wr(2, 32'd7);
    endtask

    task automatic t_polarity(); // R7 R10
        goto_pix(180); chk("R7 hsync inv", 32'(hs), 0);
                       chk("R7 vsync inv", 32'(vs), 0);
        goto_pix(182); chk("R7 hsync idle", 32'(hs), 1);
        goto_pix(183); chk("R7 de blank", 32'(de), 1);
        goto_pix(190); chk("R7 vsync idle", 32'(vs), 1);
        goto_pix(204); chk("R7 de window", 32'(de), 0);
        goto_pix(205); rd_chk("R10 frames 3", 15, 3);
    endtask

    task automatic t_stop();    // R9 R10
        wr(0, 32'd0);
        tick();
        rd_chk("R10 line off", 16, 0);
        rd_chk("R10 frame off", 15, 0);
        chk("R9 hsync idle", 32'(hs), 1);
        chk("R9 de idle", 32'(de), 1);
        chk("R9 pix idle", 32'(pix), 0);
        chk("R9 ready idle", 32'(in_ready), 0);
        chk("R9 fetch idle", 32'(fetch), 0);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_start();
        t_sync();
        t_display();
        t_active_h();
        t_active_v();
        t_polarity();
        t_stop();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule